// File: doc/BRIEF.md
# Coarse/Fine Delay Code Encoder

This block converts a requested pad delay into a configuration word for a two-stage delay line. The request has two parts. The global part is measured against fixed element sizes. The adjustment part is measured against the coarse and fine element periods that were calibrated earlier. Each part is split into whole coarse elements and a fine remainder, kept in tenths of a fine element. The two parts are summed. When the fine count grows past 22 elements, the total delay is rebuilt and split again against the calibrated periods.

The encoder is a multi-cycle datapath. One sequential divider is shared by every division step. A one-cycle `start` in idle captures the four operands. A one-cycle `done` later presents the packed word, and the word is held until the next result. A zero element period cannot be divided by, so it is reported through `err` with an all-zero word.

Top module: `dly_code_enc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `cfg_word` is 0x0000.
- R2: A `start` pulse while `busy` is 0 raises `busy` on the next cycle. Later, `done` is high for exactly one cycle and `busy` falls in that same cycle. `cfg_word` and `err` change only when `done` is high and then hold until the next `done`.
- R3: The global delay G gives a coarse part of G/920 and a fine part, in tenths, of ((G mod 920)·10)/60. All divisions are integer divisions.
- R4: The adjustment A gives a coarse part of A/CP and a fine part, in tenths, of ((A mod CP)·10)/FP. CP is `coarse_per` and FP is `fine_per`.
- R5: The coarse count C is the sum of the two coarse parts. The fine count F is the sum of the two fine tenths, divided by 10.
- R6: If F > 22, then T = C·CP + F·FP, and the counts become C = T/CP and F = (T mod CP)/FP. If F = 22 or less, C and F are kept as they are.
- R7: When `err` is 0, `cfg_word` is laid out as follows: bits [4:0] = F mod 32, bits [9:5] = C mod 32, bit 10 = 1 (lock), bit 11 = 0, and bits [15:12] = 0x9 (signature).
- R8: If CP or FP is 0, the result has `err` = 1 and `cfg_word` = 0x0000. Otherwise `err` = 0.
- R9: A `start` pulse while `busy` is 1 is ignored. It produces no extra `done` and does not change the result of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an encoding (accepted only when idle) |
| glob_dly | input | 16 | Global delay component |
| adj_dly | input | 16 | Adjustment delay component |
| coarse_per | input | 16 | Calibrated coarse element period |
| fine_per | input | 16 | Calibrated fine element period |
| busy | output | 1 | Encoding in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last result had a zero element period |
| cfg_word | output | 16 | Packed configuration word |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the operands are stable in the cycle in which `start` is sampled. They also assume that products formed during renormalisation stay within twice the operand width, which holds for 16-bit operands. The bench drives each start for exactly one cycle at a falling edge and changes operands only in that cycle. It keeps the periods at or below 16 bits, uses zero periods only in the dedicated error cases, and picks vectors on both sides of the F = 22 fold boundary.

// File: rtl/dly_enc_pkg.sv
// Package: constants and state types shared by the delay code encoder.
// Assumes the fixed global element sizes and the word layout below.
package dly_enc_pkg;
    localparam int GLB_COARSE_UNIT = 920;
    localparam int GLB_FINE_UNIT   = 60;
    localparam int TENTH_SCALE     = 10;
    localparam int FINE_FOLD_MAX   = 22;
    localparam int FINE_W          = 5;
    localparam int COARSE_W        = 5;
    localparam int WORD_W          = 16;
    localparam int LOCK_POS        = 10;
    localparam int SIG_LSB         = 12;
    localparam logic [3:0] SIG_VAL = 4'h9;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} enc_state_t;
    typedef enum logic [2:0] {SP_GQ, SP_GF, SP_AQ, SP_AF, SP_FSUM, SP_RC, SP_RF} enc_step_t;
endpackage

// File: rtl/dly_seq_div.sv
// Module: restoring radix-2 divider, one quotient bit per cycle.
// Assumes the divisor is non-zero; the caller screens out zero divisors.
// busy lasts W cycles after start; done pulses once and quot/rem then hold.
module dly_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  r_q, q_q;
    logic [W:0]    shifted, diff;
    logic          fits;

    // Trial subtraction of the divisor from the partial remainder.
    always_comb begin
        shifted = {r_q, q_q[W-1]};
        diff    = shifted - {1'b0, divisor};
        fits    = (shifted >= {1'b0, divisor});
    end

    // Iteration registers and the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q  <= '0;
            q_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                r_q  <= '0;
                q_q  <= dividend;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                r_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                q_q <= {q_q[W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_q;
    assign rem  = r_q;
endmodule

// File: rtl/dly_word_pack.sv
// Module: packs the coarse/fine counts with the lock and signature fields.
// Assumes the counts are already cut to their field widths; a fault gives zero.
module dly_word_pack
    import dly_enc_pkg::*;
(
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    input  logic                fault,
    output logic [WORD_W-1:0]   word
);
    // Field placement of the configuration word.
    always_comb begin
        word = '0;
        if (!fault) begin
            word[FINE_W-1:0]        = fine;
            word[FINE_W +: COARSE_W] = coarse;
            word[LOCK_POS]          = 1'b1;
            word[SIG_LSB +: 4]      = SIG_VAL;
        end
    end
endmodule

// File: rtl/dly_code_enc.sv
// Module: delay code encoder top. Steps one shared divider through the
// global split, the adjustment split, the fine sum and the optional fold,
// then packs the word. Assumes start is a one-cycle pulse with stable operands.
module dly_code_enc
    import dly_enc_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DLY_W-1:0]  glob_dly,
    input  logic [DLY_W-1:0]  adj_dly,
    input  logic [DLY_W-1:0]  coarse_per,
    input  logic [DLY_W-1:0]  fine_per,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] cfg_word
);
    localparam int DIV_W = 2 * DLY_W;

    enc_state_t       st;
    enc_step_t        step;
    logic [DLY_W-1:0] g_r, a_r, cp_r, fp_r;
    logic [DIV_W-1:0] c_acc, f_acc, gf_r, tmp;
    logic             fault;
    logic [DIV_W-1:0] dvd, dvs, div_q, div_r;
    logic             div_start, div_busy, div_done;
    logic [WORD_W-1:0] packed_w;

    // Operand selection for the current division step.
    always_comb begin
        dvd = tmp;
        dvs = DIV_W'(fp_r);
        unique case (step)
            SP_GQ:   begin dvd = DIV_W'(g_r);                dvs = DIV_W'(GLB_COARSE_UNIT); end
            SP_GF:   begin dvd = tmp * DIV_W'(TENTH_SCALE);  dvs = DIV_W'(GLB_FINE_UNIT);   end
            SP_AQ:   begin dvd = DIV_W'(a_r);                dvs = DIV_W'(cp_r);            end
            SP_AF:   begin dvd = tmp * DIV_W'(TENTH_SCALE);  dvs = DIV_W'(fp_r);            end
            SP_FSUM: begin dvd = f_acc;                      dvs = DIV_W'(TENTH_SCALE);     end
            SP_RC:   begin dvd = c_acc * DIV_W'(cp_r) + f_acc * DIV_W'(fp_r);
                           dvs = DIV_W'(cp_r); end
            default: begin dvd = tmp;                        dvs = DIV_W'(fp_r);            end
        endcase
    end

    assign div_start = (st == ST_ISSUE);

    dly_seq_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dvd),
        .divisor  (dvs),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (div_q),
        .rem      (div_r)
    );

    dly_word_pack u_pack (
        .coarse (c_acc[COARSE_W-1:0]),
        .fine   (f_acc[FINE_W-1:0]),
        .fault  (fault),
        .word   (packed_w)
    );

    // Sequencer: operand capture, step results, fold decision, result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            step     <= SP_GQ;
            g_r      <= '0;
            a_r      <= '0;
            cp_r     <= '0;
            fp_r     <= '0;
            c_acc    <= '0;
            f_acc    <= '0;
            gf_r     <= '0;
            tmp      <= '0;
            fault    <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            cfg_word <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    g_r   <= glob_dly;
                    a_r   <= adj_dly;
                    cp_r  <= coarse_per;
                    fp_r  <= fine_per;
                    step  <= SP_GQ;
                    fault <= (coarse_per == '0) || (fine_per == '0);
                    st    <= ((coarse_per == '0) || (fine_per == '0)) ? ST_FIN : ST_ISSUE;
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: if (div_done) begin
                    st <= ST_ISSUE;
                    unique case (step)
                        SP_GQ:   begin c_acc <= div_q; tmp <= div_r; step <= SP_GF; end
                        SP_GF:   begin gf_r <= div_q; step <= SP_AQ; end
                        SP_AQ:   begin c_acc <= c_acc + div_q; tmp <= div_r; step <= SP_AF; end
                        SP_AF:   begin f_acc <= gf_r + div_q; step <= SP_FSUM; end
                        SP_FSUM: begin
                            f_acc <= div_q;
                            if (div_q > DIV_W'(FINE_FOLD_MAX)) step <= SP_RC;
                            else st <= ST_FIN;
                        end
                        SP_RC:   begin c_acc <= div_q; tmp <= div_r; step <= SP_RF; end
                        default: begin f_acc <= div_q; st <= ST_FIN; end
                    endcase
                end
                default: begin
                    cfg_word <= packed_w;
                    err      <= fault;
                    done     <= 1'b1;
                    st       <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/dly_code_enc_chk.sv
// Module: property checker for the delay code encoder, bound to the top.
// Assumes start is a single-cycle pulse driven by a well-behaved requester.
module dly_code_enc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] cfg_word,
    input logic        div_busy
);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_word) |-> done);
    // R2
    div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !div_busy);
    // R7
    frame_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (cfg_word[15:10] == 6'b100101));
    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (cfg_word == 16'h0000));
endmodule

bind dly_code_enc dly_code_enc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .cfg_word (cfg_word),
    .div_busy (div_busy)
);

// File: tb/sim_dly_code_enc.sv
// Bench: scoreboard for the delay code encoder. The driver pushes expected
// words computed from the requirements; the monitor compares them on done.
module sim_dly_code_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] glob_dly = '0, adj_dly = '0, coarse_per = '0, fine_per = '0;
    logic        busy, done, err;
    logic [15:0] cfg_word;

    int n_cmp = 0;
    int n_bad = 0;
    int n_push = 0;
    int n_done = 0;
    logic [15:0] exp_w_q[$];
    logic        exp_e_q[$];
    string       exp_t_q[$];

    always #5 clk = ~clk;

    dly_code_enc u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .glob_dly(glob_dly), .adj_dly(adj_dly),
        .coarse_per(coarse_per), .fine_per(fine_per),
        .busy(busy), .done(done), .err(err), .cfg_word(cfg_word)
    );

    function automatic logic [15:0] model(input longint g, input longint a,
                                          input longint cp, input longint fp);
        longint c, f, t, gf, af;
        c  = g / 920 + a / cp;
        gf = ((g % 920) * 10) / 60;
        af = ((a % cp) * 10) / fp;
        f  = (gf + af) / 10;
        if (f > 22) begin
            t = c * cp + f * fp;
            c = t / cp;
            f = (t % cp) / fp;
        end
        return 16'h9400 | 16'((c & 31) << 5) | 16'(f & 31);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic issue(input string tag, input logic [15:0] g, input logic [15:0] a,
                         input logic [15:0] cp, input logic [15:0] fp);
        @(negedge clk);
        while (busy) @(negedge clk);
        glob_dly = g; adj_dly = a; coarse_per = cp; fine_per = fp;
        start = 1'b1;
        if (cp == 0 || fp == 0) begin
            exp_w_q.push_back(16'h0000); exp_e_q.push_back(1'b1);
        end else begin
            exp_w_q.push_back(model(g, a, cp, fp)); exp_e_q.push_back(1'b0);
        end
        exp_t_q.push_back(tag);
        n_push++;
        @(negedge clk);
        start = 1'b0;
        check({tag, " busy after accept (R2)"}, {31'd0, busy}, 32'd1);
    endtask

    // Monitor: compare every result against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (exp_w_q.size() == 0) begin
                check("R9 unexpected done", 32'd1, 32'd0);
            end else begin
                string t;
                t = exp_t_q.pop_front();
                check({t, " word"}, {16'd0, cfg_word}, {16'd0, exp_w_q.pop_front()});
                check({t, " err"}, {31'd0, err}, {31'd0, exp_e_q.pop_front()});
                check("R2 busy low with done", {31'd0, busy}, 32'd0);
            end
        end
    end

    task automatic run();
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {15'd0, busy, done, err, cfg_word}, 32'd0);
        // R3: global only, adjustment zero
        issue("R3", 16'd2000, 16'd0, 16'd300, 16'd20);
        issue("R3", 16'd919, 16'd0, 16'd500, 16'd25);
        // R4: adjustment only
        issue("R4", 16'd0, 16'd1234, 16'd200, 16'd13);
        // R5: both components combined
        issue("R5", 16'd1500, 16'd777, 16'd250, 16'd30);
        // R6: boundary F=22 keeps, F=23 folds (C=1, F=3)
        issue("R6", 16'd919, 16'd76, 16'd200, 16'd10);
        issue("R6", 16'd919, 16'd80, 16'd200, 16'd10);
        issue("R6", 16'd919, 16'd390, 16'd400, 16'd10);
        // R7: coarse count above 31 wraps in its field
        issue("R7", 16'd0, 16'd40000, 16'd1000, 16'd40);
        // R8: zero periods, then recovery
        issue("R8", 16'd100, 16'd100, 16'd0, 16'd10);
        issue("R8", 16'd100, 16'd100, 16'd10, 16'd0);
        issue("R8", 16'd100, 16'd100, 16'd10, 16'd3);
        // R9: a start while busy must be ignored
        issue("R9", 16'd3000, 16'd555, 16'd300, 16'd11);
        glob_dly = 16'd7; adj_dly = 16'd7; coarse_per = 16'd0; fine_per = 16'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R5: pseudo-random sweep
        lf = 32'hACE1_2345;
        for (int i = 0; i < 30; i++) begin
            logic [15:0] cp, fp;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = lf * 32'd1103515245 + 32'd12345;
            cp = 16'(lf[9:0]) + 16'd1;
            fp = 16'(lf[17:10]) + 16'd1;
            issue("R5 sweep", lf[31:16], lf[25:10] ^ lf[15:0], cp, fp);
        end
        @(negedge clk);
        while (busy || done) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9 result count", n_done, n_push);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule